// File: doc/BRIEF.md
# CAN Receive Queue Status Controller

This block holds the status and control state for a receive queue of up to three CAN messages. The message payloads are kept in an external store. When the acceptance filter passes a frame, the bit-level receiver pulses `msg_valid` for one cycle. The block then decides whether the frame is kept. It raises `store_en` for a kept frame and gives the slot index on `wr_ptr`. The slot that software reads next, called the output mailbox, is given on `rd_ptr`.

Software uses two byte-wide registers, chosen by `reg_sel`. The status register (select 0) has these fields:
- bit 5: release request.
- bit 4: overrun flag.
- bit 3: full flag.
- bits 1:0: pending-message count.
- bits 7:6 and bit 2: always read 0.

The enable register (select 1) holds one enable bit for each interrupt source. Software frees the output mailbox by writing 1 to the release bit. Hardware clears that bit by itself one cycle later, and the count drops at the same time. The two flags are cleared in different ways: the overrun flag only by writing 1 to it, and the full flag either by writing 1 to it or by a completed release. The message-pending interrupt fires only when the queue goes from empty to one message.

There is no back-pressure on the receive side. `msg_valid` is a plain strobe with no ready return, because the CAN bus cannot be stalled. A frame that arrives while the queue is full is dropped and recorded in the overrun flag. `store_en` is a qualifier for the external store, not a handshake.

Top module: `rxq_status_ctrl`

## Requirements
- R1: Reset leaves both registers at 0x00, both pointers at 0 and `irq` low. Each kept frame raises the pending count in status bits 1:0 by one. The count never exceeds 3.
- R2: Writing 1 to status bit 5 while the count is nonzero makes bit 5 read 1 after that edge. On the next edge bit 5 returns to 0, the count drops by one and `rd_ptr` advances modulo 3.
- R3: Writing 1 to status bit 5 has no effect in two cases: when the count is 0, and when a release is already in progress.
- R4: Full (status bit 3) is set when the count reaches 3. It is cleared by writing 1 to bit 3 or by a completed release. Writing 0 to a flag bit leaves it unchanged.
- R5: A frame that arrives at count 3 with no release completing in that cycle is dropped. `store_en` stays low, `wr_ptr` does not move, and overrun (status bit 4) is set. Overrun is cleared only by writing 1 to bit 4.
- R6: When a flag is set by hardware and cleared by a write of 1 in the same cycle, the set wins.
- R7: When a frame arrives in the same cycle a release completes, the frame is kept and the count is unchanged. Both pointers advance, and full is cleared.
- R8: The enable register (select 1) has three read/write bits: bit 3 enables the overrun interrupt, bit 2 the full interrupt and bit 1 the message-pending interrupt. All other bits read 0.
- R9: `irq` is the OR of three terms: overrun AND its enable, full AND its enable, and a pending latch AND its enable. The pending latch is set when the count goes from 0 to 1 and cleared by any completed release.
- R10: `store_en` is high, in the same cycle as `msg_valid`, for each frame that is kept. After that edge `wr_ptr` advances modulo 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | One-cycle strobe for a frame accepted by the filter |
| store_en | output | 1 | Write enable to the payload store for the current frame |
| wr_ptr | output | 2 | Slot that receives the next kept frame |
| rd_ptr | output | 2 | Slot of the output mailbox |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 for status, 1 for enables |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
`store_en` follows `msg_valid` within the same cycle. `reg_rdata` and `irq` follow the registers they read from within the same cycle. The count, the flags, the pointers and the enables change one edge after the input that causes them. A release shows on bit 5 one edge after the write, and its effect on the count shows one edge after that. The bench drives inputs on the falling edge and checks registered results 1 ns after the next rising edge. It checks `store_en` before that edge, so each result is read in the cycle it is due.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int REG_W   = 8;
  // status register field positions
  localparam int ST_REL  = 5;
  localparam int ST_OVR  = 4;
  localparam int ST_FULL = 3;
  // enable register field positions
  localparam int IE_OVR  = 3;
  localparam int IE_FULL = 2;
  localparam int IE_PEND = 1;

  typedef struct packed {
    logic rel_req;
    logic clr_ovr;
    logic clr_full;
  } sw_cmd_t;

  typedef struct packed {
    logic fill;
    logic drop;
    logic first;
    logic rel_done;
  } hw_evt_t;
endpackage

// File: rtl/rxq_occupancy.sv
module rxq_occupancy #(
  parameter int DEPTH = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic             rel_req,
  output logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             rel_busy,
  output logic             store_en,
  output rxq_pkg::hw_evt_t evt
);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] NEAR = CNT_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic             at_cap;
  logic             rel_done;
  logic             rel_accept;
  logic [CNT_W-1:0] cnt_nxt;
  logic [PTR_W-1:0] wr_inc, rd_inc;

  assign at_cap     = (cnt == CAP);
  assign rel_done   = rel_busy;
  assign store_en   = msg_valid && (!at_cap || rel_done);
  assign rel_accept = rel_req && !rel_busy && (cnt != '0);

  assign evt.fill     = store_en && !rel_done && (cnt == NEAR);
  assign evt.drop     = msg_valid && !store_en;
  assign evt.first    = store_en && !rel_done && (cnt == '0);
  assign evt.rel_done = rel_done;

  // pointer wrap: free-running when the depth fills the index space
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_inc = wr_ptr + PTR_W'(1);
      assign rd_inc = rd_ptr + PTR_W'(1);
    end else begin : g_mod
      assign wr_inc = (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_inc = (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  always_comb begin
    cnt_nxt = cnt;
    if (store_en && !rel_done)      cnt_nxt = cnt + CNT_W'(1);
    else if (!store_en && rel_done) cnt_nxt = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      rel_busy <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (store_en) wr_ptr <= wr_inc;
      if (rel_done) rd_ptr <= rd_inc;
      if (rel_done)        rel_busy <= 1'b0;
      else if (rel_accept) rel_busy <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
  input  logic             clk,
  input  logic             rst_n,
  input  rxq_pkg::hw_evt_t evt,
  input  rxq_pkg::sw_cmd_t cmd,
  output logic             full,
  output logic             ovr,
  output logic             pend_hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      ovr       <= 1'b0;
      pend_hold <= 1'b0;
    end else begin
      // hardware set takes priority over a software clear
      if (evt.fill)                          full <= 1'b1;
      else if (evt.rel_done || cmd.clr_full) full <= 1'b0;

      if (evt.drop)         ovr <= 1'b1;
      else if (cmd.clr_ovr) ovr <= 1'b0;

      if (evt.first)         pend_hold <= 1'b1;
      else if (evt.rel_done) pend_hold <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_regview.sv
module rxq_regview #(
  parameter int CNT_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr_en,
  input  logic                        reg_sel,
  input  logic [rxq_pkg::REG_W-1:0]   reg_wdata,
  input  logic [CNT_W-1:0]            cnt,
  input  logic                        rel_busy,
  input  logic                        full,
  input  logic                        ovr,
  input  logic                        pend_hold,
  output logic [rxq_pkg::REG_W-1:0]   reg_rdata,
  output rxq_pkg::sw_cmd_t            cmd,
  output logic                        irq
);
  import rxq_pkg::*;

  logic wr_stat, wr_ien;
  logic en_ovr, en_full, en_pend;
  logic [REG_W-1:0] stat_view, ien_view;
  logic unused_wbits;

  assign wr_stat = reg_wr_en && !reg_sel;
  assign wr_ien  = reg_wr_en &&  reg_sel;

  assign cmd.rel_req  = wr_stat && reg_wdata[ST_REL];
  assign cmd.clr_ovr  = wr_stat && reg_wdata[ST_OVR];
  assign cmd.clr_full = wr_stat && reg_wdata[ST_FULL];

  assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ovr  <= 1'b0;
      en_full <= 1'b0;
      en_pend <= 1'b0;
    end else if (wr_ien) begin
      en_ovr  <= reg_wdata[IE_OVR];
      en_full <= reg_wdata[IE_FULL];
      en_pend <= reg_wdata[IE_PEND];
    end
  end

  always_comb begin
    stat_view              = '0;
    stat_view[CNT_W-1:0]   = cnt;
    stat_view[ST_FULL]     = full;
    stat_view[ST_OVR]      = ovr;
    stat_view[ST_REL]      = rel_busy;
    ien_view               = '0;
    ien_view[IE_OVR]       = en_ovr;
    ien_view[IE_FULL]      = en_full;
    ien_view[IE_PEND]      = en_pend;
  end

  assign reg_rdata = reg_sel ? ien_view : stat_view;
  assign irq = (ovr && en_ovr) || (full && en_full) || (pend_hold && en_pend);
endmodule

// File: rtl/rxq_status_ctrl.sv
module rxq_status_ctrl #(
  parameter int DEPTH = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             store_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  input  logic             reg_wr_en,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  rxq_pkg::sw_cmd_t cmd;
  rxq_pkg::hw_evt_t evt;
  logic [CNT_W-1:0] pend_cnt;
  logic             rel_busy;
  logic             full_flag, ovr_flag, pend_hold;

  rxq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_valid(msg_valid),
    .rel_req  (cmd.rel_req),
    .cnt      (pend_cnt),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .rel_busy (rel_busy),
    .store_en (store_en),
    .evt      (evt)
  );

  rxq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .cmd      (cmd),
    .full     (full_flag),
    .ovr      (ovr_flag),
    .pend_hold(pend_hold)
  );

  rxq_regview #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .cnt      (pend_cnt),
    .rel_busy (rel_busy),
    .full     (full_flag),
    .ovr      (ovr_flag),
    .pend_hold(pend_hold),
    .reg_rdata(reg_rdata),
    .cmd      (cmd),
    .irq      (irq)
  );
endmodule

// File: rtl/rxq_status_ctrl_chk.sv
module rxq_status_ctrl_chk #(
  parameter int DEPTH = 3,
  parameter int PTR_W = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             store_en,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             stat_wr,
  input logic             rel_bit,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             rel_busy,
  input logic             full,
  input logic             ovr
);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] NEAR = CNT_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);

  assert_release_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_busy |=> !rel_busy);

  assert_release_drops_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_busy && !store_en) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_empty_release_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && rel_bit && cnt == '0) |=> !rel_busy);

  assert_full_at_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && !rel_busy && cnt == NEAR) |=> full);

  assert_overrun_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !store_en) |=> ovr);

  assert_drop_keeps_wptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !store_en) |=> $stable(wr_ptr));

  assert_combined_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && rel_busy) |=> ($stable(cnt) && !full));

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (full || ovr || cnt != '0));

  assert_ptr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr <= LAST) && (rd_ptr <= LAST));
endmodule

bind rxq_status_ctrl rxq_status_ctrl_chk #(
  .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .msg_valid(msg_valid),
  .store_en (store_en),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr),
  .stat_wr  (reg_wr_en && !reg_sel),
  .rel_bit  (reg_wdata[5]),
  .irq      (irq),
  .cnt      (pend_cnt),
  .rel_busy (rel_busy),
  .full     (full_flag),
  .ovr      (ovr_flag)
);

// File: tb/rxq_status_ctrl_test.sv
`timescale 1ns/1ps
module rxq_status_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msg_valid = 1'b0;
  logic       store_en;
  logic [1:0] wr_ptr, rd_ptr;
  logic       reg_wr_en = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rxq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .store_en(store_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic       mv;
    logic       we;
    logic       sel;
    logic [7:0] wd;
    logic [7:0] st;
    logic       ir;
    logic [1:0] wp;
    logic [1:0] rp;
  } vec_t;

  localparam int NV = 33;
  // mv we sel wdata | status irq wp rp (status read after the edge)
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,8'h0E, 8'h00,1'b0,2'd0,2'd0}, // 0  R8 enable all
    '{1'b1,1'b0,1'b0,8'h00, 8'h01,1'b1,2'd1,2'd0}, // 1  R1 R9 first frame
    '{1'b1,1'b0,1'b0,8'h00, 8'h02,1'b1,2'd2,2'd0}, // 2  R1
    '{1'b1,1'b0,1'b0,8'h00, 8'h0B,1'b1,2'd0,2'd0}, // 3  R4 R10 full, wrap
    '{1'b1,1'b0,1'b0,8'h00, 8'h1B,1'b1,2'd0,2'd0}, // 4  R5 drop
    '{1'b0,1'b1,1'b0,8'h10, 8'h0B,1'b1,2'd0,2'd0}, // 5  R5 clear overrun
    '{1'b0,1'b1,1'b0,8'h08, 8'h03,1'b1,2'd0,2'd0}, // 6  R4 clear full
    '{1'b0,1'b1,1'b0,8'h20, 8'h23,1'b1,2'd0,2'd0}, // 7  R2 request
    '{1'b0,1'b0,1'b0,8'h00, 8'h02,1'b0,2'd0,2'd1}, // 8  R2 R9 done
    '{1'b0,1'b1,1'b0,8'h20, 8'h22,1'b0,2'd0,2'd1}, // 9  R2
    '{1'b0,1'b0,1'b0,8'h00, 8'h01,1'b0,2'd0,2'd2}, // 10 R2
    '{1'b1,1'b0,1'b0,8'h00, 8'h02,1'b0,2'd1,2'd2}, // 11 R9 no edge 1->2
    '{1'b1,1'b0,1'b0,8'h00, 8'h0B,1'b1,2'd2,2'd2}, // 12 R4 R9
    '{1'b0,1'b1,1'b0,8'h20, 8'h2B,1'b1,2'd2,2'd2}, // 13 R2
    '{1'b1,1'b0,1'b0,8'h00, 8'h03,1'b0,2'd0,2'd0}, // 14 R7 store+release
    '{1'b0,1'b1,1'b1,8'h00, 8'h03,1'b0,2'd0,2'd0}, // 15 R8 disable
    '{1'b1,1'b0,1'b0,8'h00, 8'h13,1'b0,2'd0,2'd0}, // 16 R5 R9 masked
    '{1'b0,1'b1,1'b1,8'h08, 8'h13,1'b1,2'd0,2'd0}, // 17 R9 overrun only
    '{1'b0,1'b1,1'b0,8'h20, 8'h33,1'b1,2'd0,2'd0}, // 18 R2
    '{1'b0,1'b0,1'b0,8'h00, 8'h12,1'b1,2'd0,2'd1}, // 19 R2
    '{1'b0,1'b1,1'b0,8'h20, 8'h32,1'b1,2'd0,2'd1}, // 20 R2
    '{1'b0,1'b0,1'b0,8'h00, 8'h11,1'b1,2'd0,2'd2}, // 21 R2
    '{1'b0,1'b1,1'b0,8'h20, 8'h31,1'b1,2'd0,2'd2}, // 22 R2
    '{1'b0,1'b0,1'b0,8'h00, 8'h10,1'b1,2'd0,2'd0}, // 23 R2 rd wrap
    '{1'b0,1'b1,1'b0,8'h20, 8'h10,1'b1,2'd0,2'd0}, // 24 R3 empty release
    '{1'b0,1'b1,1'b0,8'h30, 8'h00,1'b0,2'd0,2'd0}, // 25 R3 R5
    '{1'b0,1'b1,1'b1,8'h02, 8'h00,1'b0,2'd0,2'd0}, // 26 R8 pending only
    '{1'b1,1'b0,1'b0,8'h00, 8'h01,1'b1,2'd1,2'd0}, // 27 R9 0->1
    '{1'b1,1'b0,1'b0,8'h00, 8'h02,1'b1,2'd2,2'd0}, // 28 R1
    '{1'b1,1'b1,1'b0,8'h08, 8'h0B,1'b1,2'd0,2'd0}, // 29 R6 set wins
    '{1'b0,1'b1,1'b0,8'h20, 8'h2B,1'b1,2'd0,2'd0}, // 30 R2
    '{1'b0,1'b1,1'b0,8'h20, 8'h02,1'b0,2'd0,2'd1}, // 31 R3 busy write ignored
    '{1'b0,1'b0,1'b0,8'h00, 8'h02,1'b0,2'd0,2'd1}  // 32 R3 no second release
  };

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check_reset_state(input string tag);
    reg_sel = 1'b0;
    #0.5;
    check({tag, " status"}, reg_rdata, 8'h00);
    check({tag, " wr_ptr"}, wr_ptr, 0);
    check({tag, " rd_ptr"}, rd_ptr, 0);
    check({tag, " irq"}, irq, 0);
    reg_sel = 1'b1;
    #0.5;
    check({tag, " enables"}, reg_rdata, 8'h00);
    reg_sel = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check_reset_state("R1 reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      msg_valid = VEC[i].mv;
      reg_wr_en = VEC[i].we;
      reg_sel   = VEC[i].sel;
      reg_wdata = VEC[i].wd;
      @(posedge clk);
      #1;
      msg_valid = 1'b0;
      reg_wr_en = 1'b0;
      reg_sel   = 1'b0;
      reg_wdata = 8'h00;
      #0.5;
      check($sformatf("vec%0d R1 R2 R4 R5 R6 R7 status", i), reg_rdata, VEC[i].st);
      check($sformatf("vec%0d R9 irq", i), irq, VEC[i].ir);
      check($sformatf("vec%0d R10 wr_ptr", i), wr_ptr, VEC[i].wp);
      check($sformatf("vec%0d R2 rd_ptr", i), rd_ptr, VEC[i].rp);
    end

    // R8: reserved enable bits read 0
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 8'hFF;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; reg_wdata = 8'h00;
    #0.5;
    check("R8 enable readback", reg_rdata, 8'h0E);
    reg_sel = 1'b0;

    // R10: store_en in the cycle of a kept frame (count is 2 here)
    @(negedge clk);
    msg_valid = 1'b1;
    #1;
    check("R10 store_en on kept frame", store_en, 1);
    @(posedge clk); #1;
    msg_valid = 1'b0;
    #0.5;
    check("R10 wr_ptr advance", wr_ptr, 1);

    // R5: store_en low for a frame at count 3
    @(negedge clk);
    msg_valid = 1'b1;
    #1;
    check("R5 store_en low when full", store_en, 0);
    @(posedge clk); #1;
    msg_valid = 1'b0;
    #0.5;
    check("R5 wr_ptr held on drop", wr_ptr, 1);
    check("R5 overrun after drop", reg_rdata, 8'h1B);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule